// File: doc/BRIEF.md
# Triggered Sample Capture Controller

This block is the acquisition core of a small logic analyzer. It watches a wide probe bus, and once the host has armed it, it waits for the probe word to agree with a host-chosen pattern on every bit the host has selected in a mask. When that happens it starts a capture run. On each sample period it stores one slice of the probe word into an external static RAM, and it steps the RAM address upward after each period. When the address has covered the whole RAM, the run ends.

The sample rate is set by a programmable divider of the system clock. The write strobe to the RAM is active low and is confined to the second half of each sample period, so that address and data have settled before the strobe arrives. The host reads the state of the run through three status lines: armed, capturing and done. It can cancel any run with a disarm pulse.

Top module: `tcap_capture`

## Requirements
- R1: The trigger hits when `((probe XOR pattern) AND mask) == 0`. A mask bit of 1 makes that probe bit take part in the compare, and a mask bit of 0 makes it a don't-care.
- R2: After reset, and in the idle state, a hitting probe word never starts a capture. Only an `arm_i` pulse moves the block from idle to armed.
- R3: In the armed state, a sample tick that finds the trigger hitting starts a capture. The address is 0 and the stored data is the probe slice present at that tick.
- R4: During capture, each later sample tick raises the address by one and loads the probe slice present at that tick. The slice is bits `[LANE*RAM_DW +: RAM_DW]` of the probe bus.
- R5: `ram_we_n_o` is low only while capturing, and only in the cycles of a sample period whose position count is at least `(div+1)/2`, counting from 0. With a divider value of 0, it is low in every capture cycle.
- R6: A sample tick occurs once every `div+1` system clocks. A divider value of 0 gives one tick per clock.
- R7: A tick in capture at address all-ones ends the run. The block then shows done, the address returns to 0 and the strobe stays high. Done is held until an arm or a disarm pulse.
- R8: A disarm pulse returns the block to idle from any state at the next edge, and it wins over a simultaneous arm.
- R9: An arm pulse is ignored while armed or capturing: the address keeps stepping and the capture continues. From idle or done it re-arms the block.
- R10: Reset clears all status outputs, drives the address to 0 and holds the write strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_i | input | PROBE_W | Latched probe word |
| trig_pat_i | input | PROBE_W | Trigger pattern |
| trig_mask_i | input | PROBE_W | Trigger compare mask, 1 = compare |
| rate_div_i | input | DIV_W | Sample divider value N, period N+1 clocks |
| arm_i | input | 1 | Arm pulse |
| disarm_i | input | 1 | Disarm pulse, returns to idle |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_data_o | output | RAM_DW | RAM write data |
| ram_we_n_o | output | 1 | RAM write strobe, active low |
| armed_o | output | 1 | Waiting for trigger |
| capturing_o | output | 1 | Capture run in progress |
| done_o | output | 1 | Capture run completed |

## Verification
The bench builds the block with a 4-bit address, so a full run of 16 samples ends with the wrap to done within a few dozen clocks, and the hold of the done state can be observed. It selects lane 1 of a 32-bit probe with a 16-bit RAM word, which exercises the sliced data path rather than the pass-through variant. A 4-bit divider allows both the undivided rate and a four-clock period, where the split of the strobe into two high cycles and two low cycles, and the address step, can be seen cycle by cycle.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_CAPT  = 2'd2,
      ST_DONE  = 2'd3
   } cap_state_e;
endpackage

// File: rtl/tcap_rate_div.sv
// Sample-rate divider: a tick every div_i+1 clocks, plus a flag for the
// late half of the current period.
module tcap_rate_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o,
   output logic             late_o
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W:0]   span_w;
   logic [DIV_W:0]   half_w;

   assign span_w = {1'b0, div_i} + {{DIV_W{1'b0}}, 1'b1};
   assign half_w = span_w >> 1;
   assign tick_o = (cnt_q >= div_i);
   assign late_o = ({1'b0, cnt_q} >= half_w);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   // R6: every period restarts from position 0 after a tick
   p_cnt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (cnt_q == '0));
   // R5: the closing cycle of a period always lies in the late half
   p_late_at_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> late_o);
endmodule

// File: rtl/tcap_trig_cmp.sv
// Masked pattern compare, one miss bit per probe line.
module tcap_trig_cmp #(
   parameter int W = 32
) (
   input  logic [W-1:0] probe_i,
   input  logic [W-1:0] pat_i,
   input  logic [W-1:0] mask_i,
   output logic         hit_o
);
   logic [W-1:0] miss_w;

   for (genvar b = 0; b < W; b++) begin : g_bit
      assign miss_w[b] = mask_i[b] & (probe_i[b] ^ pat_i[b]);
   end

   assign hit_o = ~|miss_w;
endmodule

// File: rtl/tcap_seq.sv
// Arm / trigger / capture / done sequencer and the RAM address counter.
module tcap_seq
   import tcap_pkg::*;
#(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              disarm_i,
   input  logic              tick_i,
   input  logic              hit_i,
   output cap_state_e        state_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              take_o
);
   localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

   cap_state_e        cur_q, nxt_w;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic              take_w;

   always_comb begin
      nxt_w  = cur_q;
      addr_d = addr_q;
      take_w = 1'b0;
      if (disarm_i) begin
         nxt_w = ST_IDLE;
      end else begin
         case (cur_q)
            ST_IDLE, ST_DONE: begin
               if (arm_i) begin
                  nxt_w  = ST_ARMED;
                  addr_d = '0;
               end
            end
            ST_ARMED: begin
               if (tick_i && hit_i) begin
                  nxt_w  = ST_CAPT;
                  addr_d = '0;
                  take_w = 1'b1;
               end
            end
            ST_CAPT: begin
               if (tick_i) begin
                  if (addr_q == ADDR_LAST) begin
                     nxt_w  = ST_DONE;
                     addr_d = '0;
                  end else begin
                     addr_d = addr_q + 1'b1;
                     take_w = 1'b1;
                  end
               end
            end
            default: nxt_w = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= ST_IDLE;
         addr_q <= '0;
      end else begin
         cur_q  <= nxt_w;
         addr_q <= addr_d;
      end
   end

   assign state_o = cur_q;
   assign addr_o  = addr_q;
   assign take_o  = take_w;

   // R4: each capture tick below the top steps the address by one
   p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == ST_CAPT && tick_i && !disarm_i && addr_q != ADDR_LAST)
      |=> (cur_q == ST_CAPT && addr_q == $past(addr_q) + 1'b1));
   // R7: the tick at the top address ends the run with the address at zero
   p_wrap_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == ST_CAPT && tick_i && !disarm_i && addr_q == ADDR_LAST)
      |=> (cur_q == ST_DONE && addr_q == '0));
   // R7: done is held without a command
   p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == ST_DONE && !arm_i && !disarm_i) |=> (cur_q == ST_DONE));
   // R8: disarm always lands in idle
   p_disarm_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      disarm_i |=> (cur_q == ST_IDLE));
   // R2: idle never jumps straight into capture
   p_idle_no_capt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == ST_IDLE) |=> (cur_q != ST_CAPT));
   // R9: between ticks an arm pulse leaves a capture untouched
   p_arm_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == ST_CAPT && !disarm_i && !tick_i)
      |=> (cur_q == ST_CAPT && $stable(addr_q)));
endmodule

// File: rtl/tcap_sram_wr.sv
// RAM write side: lane select, sample register and write strobe.
module tcap_sram_wr #(
   parameter int PROBE_W = 32,
   parameter int RAM_DW  = 16,
   parameter int LANE    = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PROBE_W-1:0] probe_i,
   input  logic               take_i,
   input  logic               capt_i,
   input  logic               late_i,
   output logic [RAM_DW-1:0]  data_o,
   output logic               we_n_o
);
   logic [RAM_DW-1:0] lane_w;
   logic [RAM_DW-1:0] data_q;

   if (PROBE_W == RAM_DW) begin : g_full
      assign lane_w = probe_i;
   end else begin : g_slice
      if (RAM_DW * (LANE + 1) > PROBE_W || LANE < 0) begin : g_bad
         $error("tcap_sram_wr: LANE selects bits outside the probe bus");
      end
      assign lane_w = probe_i[LANE*RAM_DW +: RAM_DW];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      data_q <= '0;
      else if (take_i) data_q <= lane_w;
   end

   assign data_o = data_q;
   assign we_n_o = ~(capt_i & late_i);

   // R4: a load request stores the selected probe slice
   p_take_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (data_o == $past(lane_w)));
   // R5: held data stays put while no load is requested
   p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> $stable(data_o));
endmodule

// File: rtl/tcap_capture.sv
// Triggered sample capture controller, top level.
module tcap_capture
   import tcap_pkg::*;
#(
   parameter int PROBE_W = 32,
   parameter int RAM_DW  = 16,
   parameter int ADDR_W  = 14,
   parameter int DIV_W   = 8,
   parameter int LANE    = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PROBE_W-1:0] probe_i,
   input  logic [PROBE_W-1:0] trig_pat_i,
   input  logic [PROBE_W-1:0] trig_mask_i,
   input  logic [DIV_W-1:0]   rate_div_i,
   input  logic               arm_i,
   input  logic               disarm_i,
   output logic [ADDR_W-1:0]  ram_addr_o,
   output logic [RAM_DW-1:0]  ram_data_o,
   output logic               ram_we_n_o,
   output logic               armed_o,
   output logic               capturing_o,
   output logic               done_o
);
   if (PROBE_W < 1 || RAM_DW < 1 || RAM_DW > PROBE_W) begin : g_chk_w
      $error("tcap_capture: RAM word must be 1..PROBE_W bits");
   end
   if (ADDR_W < 1 || DIV_W < 1) begin : g_chk_a
      $error("tcap_capture: ADDR_W and DIV_W must be positive");
   end

   logic       tick_w, late_w, hit_w, take_w;
   cap_state_e state_w;

   tcap_rate_div #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .div_i  (rate_div_i),
      .tick_o (tick_w),
      .late_o (late_w)
   );

   tcap_trig_cmp #(.W(PROBE_W)) u_cmp (
      .probe_i (probe_i),
      .pat_i   (trig_pat_i),
      .mask_i  (trig_mask_i),
      .hit_o   (hit_w)
   );

   tcap_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_i    (arm_i),
      .disarm_i (disarm_i),
      .tick_i   (tick_w),
      .hit_i    (hit_w),
      .state_o  (state_w),
      .addr_o   (ram_addr_o),
      .take_o   (take_w)
   );

   tcap_sram_wr #(.PROBE_W(PROBE_W), .RAM_DW(RAM_DW), .LANE(LANE)) u_wr (
      .clk    (clk),
      .rst_n  (rst_n),
      .probe_i(probe_i),
      .take_i (take_w),
      .capt_i (state_w == ST_CAPT),
      .late_i (late_w),
      .data_o (ram_data_o),
      .we_n_o (ram_we_n_o)
   );

   assign armed_o     = (state_w == ST_ARMED);
   assign capturing_o = (state_w == ST_CAPT);
   assign done_o      = (state_w == ST_DONE);

   // R5: strobe only while capturing
   p_we_in_capt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n_o |-> capturing_o);
   // R10: status lines are mutually exclusive
   p_status_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({armed_o, capturing_o, done_o}));
endmodule

// File: tb/tcap_capture_tb_top.sv
module tcap_capture_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int PROBE_W = 32;
   localparam int RAM_DW  = 16;
   localparam int ADDR_W  = 4;
   localparam int DIV_W   = 4;
   localparam int LANE    = 1;

   // {probe, pattern, mask}
   localparam logic [95:0] VEC [0:7] = '{
      {32'hA5A5_0000, 32'hA5A5_FFFF, 32'hFFFF_0000},
      {32'h0000_0001, 32'h0000_0000, 32'h0000_0001},
      {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
      {32'h1234_5678, 32'h1234_5678, 32'hFFFF_FFFF},
      {32'h1234_5679, 32'h1234_5678, 32'hFFFF_FFFF},
      {32'h8000_0000, 32'h0000_0000, 32'h8000_0000},
      {32'h8000_0000, 32'h0000_0000, 32'h7FFF_FFFF},
      {32'h0F0F_0F0F, 32'hF0F0_0F0F, 32'h0000_FFFF}
   };
   localparam logic [7:0] VEXP = 8'b1100_1101;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [PROBE_W-1:0] probe = '0, pat = '0, mask = '0;
   logic [DIV_W-1:0]   div = '0;
   logic               arm = 1'b0, disarm = 1'b0;
   logic [ADDR_W-1:0]  addr;
   logic [RAM_DW-1:0]  data;
   logic               we_n, armed, capt, done;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tcap_capture #(.PROBE_W(PROBE_W), .RAM_DW(RAM_DW), .ADDR_W(ADDR_W),
                  .DIV_W(DIV_W), .LANE(LANE)) dut_i (
      .clk(clk), .rst_n(rst_n), .probe_i(probe), .trig_pat_i(pat),
      .trig_mask_i(mask), .rate_div_i(div), .arm_i(arm), .disarm_i(disarm),
      .ram_addr_o(addr), .ram_data_o(data), .ram_we_n_o(we_n),
      .armed_o(armed), .capturing_o(capt), .done_o(done)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [PROBE_W-1:0] samp(input int k);
      return {16'h1000 + 16'(k), 16'hBEEF};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int a;
      int seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 armed", armed, 0);
      chk("R10 capt", capt, 0);
      chk("R10 done", done, 0);
      chk("R10 we_n", we_n, 1);
      chk("R10 addr", addr, 0);

      // R2: hitting probe without arm
      mask = '0;
      probe = 32'hDEAD_BEEF;
      repeat (3) step();
      chk("R2 no capture unarmed", capt, 0);
      chk("R2 not armed", armed, 0);

      // R1 table of compare vectors
      for (int i = 0; i < 8; i++) begin
         disarm = 1'b1;
         probe = VEC[i][95:64];
         pat   = VEC[i][63:32];
         mask  = VEC[i][31:0];
         step();
         disarm = 1'b0;
         arm = 1'b1;
         step();
         arm = 1'b0;
         chk("R9 arm from idle", armed, 1);
         step();
         chk($sformatf("R1 vector %0d", i), capt, VEXP[i]);
      end

      // R3/R4/R5/R7: full run at undivided rate
      disarm = 1'b1; div = '0; mask = '0;
      step();
      disarm = 1'b0; arm = 1'b1;
      step();
      arm = 1'b0; probe = samp(0);
      step();
      chk("R3 capture started", capt, 1);
      chk("R3 addr zero", addr, 0);
      chk("R3 first sample", data, 32'h1000);
      chk("R5 strobe low div0", we_n, 0);
      for (int k = 1; k < 16; k++) begin
         probe = samp(k);
         step();
         chk($sformatf("R4 addr %0d", k), addr, k);
         chk($sformatf("R4 data %0d", k), data, 32'h1000 + k);
      end
      step();
      chk("R7 done", done, 1);
      chk("R7 addr wrapped", addr, 0);
      chk("R7 strobe high", we_n, 1);
      step(); step();
      chk("R7 done held", done, 1);

      // R9: re-arm from done, then arm ignored during capture
      arm = 1'b1;
      step();
      arm = 1'b0;
      chk("R9 rearm from done", armed, 1);
      step(); step(); step();
      chk("R9 capturing", capt, 1);
      a = int'(addr);
      arm = 1'b1;
      step();
      arm = 1'b0;
      chk("R9 arm ignored capt", capt, 1);
      chk("R9 arm ignored addr", addr, a + 1);

      // R8: disarm during capture, and disarm beats arm
      disarm = 1'b1;
      step();
      disarm = 1'b0;
      chk("R8 idle after disarm", {armed, capt, done}, 0);
      chk("R8 strobe high", we_n, 1);
      disarm = 1'b1; arm = 1'b1;
      step();
      disarm = 1'b0; arm = 1'b0;
      chk("R8 disarm wins", armed, 0);

      // R5/R6: divided rate, period 4
      div = 4'd3;
      arm = 1'b1;
      step();
      arm = 1'b0;
      seen = 0;
      for (int t = 0; t < 10 && seen == 0; t++) begin
         step();
         if (capt) seen = 1;
      end
      chk("R6 trigger seen", seen, 1);
      for (int j = 0; j < 8; j++) begin
         chk($sformatf("R5 strobe pos %0d", j), we_n, (j % 4) < 2);
         chk($sformatf("R6 addr pos %0d", j), addr, j / 4);
         step();
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule